// File: doc/BRIEF.md
# Receive Buffer Watermark Controller

This block watches the fill level of up to eight receive packet-buffer partitions. It counts each partition's fill in 64-byte credits and raises three flags for each partition: a flow-control pause request, a drop flag and a congestion-mark (ECN) flag. Upstream logic sends one enqueue pulse per credit written into a partition and one dequeue pulse per credit read out. The thresholds are not programmed one by one. The block derives all of them from the partition size, which is given in 2 KB units, using a fixed pause skid and a fixed maximum-frame margin.

Three enable masks, one bit per partition, turn each kind of threshold on or off. A disabled threshold is parked at an all-ones sentinel that occupancy can never reach. A global input gates only the pause outputs, so drop and marking still work while link-level pause is off. Writing a partition's size takes effect on the next cycle and empties that partition's occupancy count.

Top module: `rxb_watermark`

## Requirements
- R1: After reset every flag output is low, every occupancy count is zero, every size is zero, and the masks hold their defaults: drop 0x7D, pause 0x14, ECN 0x10. Bit i of a mask belongs to partition i.
- R2: On a clock edge, an enqueue pulse without a dequeue pulse adds one credit and a dequeue pulse without an enqueue pulse removes one. Both pulses together leave the count unchanged. The count stops at zero and at the capacity, which is size*32+4 for a used partition and 0 for a partition of size zero.
- R3: A partition of size zero keeps all three flags low and its occupancy at zero.
- R4: The pause state of a used partition turns on when occupancy is at least max(size*32-896, 0). After that it stays on while occupancy is above 896, and turns off once occupancy is at or below 896.
- R5: The drop flag of a used partition is high exactly when occupancy is at least max(size*32-152, 0). The value 152 is one 9728-byte frame in credits.
- R6: The ECN flag of a used partition is high exactly when occupancy is at least max(size*8, 152).
- R7: When a partition's mask bit is clear, the matching thresholds become 0x1FFF, so that flag stays low. For pause, both the on and the off threshold become 0x1FFF.
- R8: pause_req is the pause state ANDed with pause_glb_en. The pause state keeps tracking while pause_glb_en is low, and drop and ECN do not depend on it.
- R9: A size write (cfg_size_we with cfg_idx and cfg_size) replaces that partition's size on the clock edge. On the same edge it clears that partition's occupancy and pause state, and it wins over pulses arriving in the same cycle.
- R10: A mask write (cfg_mask_we) loads all three masks on the clock edge and leaves occupancy untouched.
- R11: The flags follow the registered state combinationally, so a pulse or write shows on the outputs right after the edge that takes it in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq | input | NP | One-credit enqueue pulse per partition |
| deq | input | NP | One-credit dequeue pulse per partition |
| cfg_size_we | input | 1 | Size write strobe |
| cfg_idx | input | $clog2(NP) | Partition selected by a size write |
| cfg_size | input | SW | New size in 2 KB units, 0 = unused |
| cfg_mask_we | input | 1 | Mask write strobe |
| cfg_drop_mask | input | NP | New drop enable mask |
| cfg_pause_mask | input | NP | New pause enable mask |
| cfg_ecn_mask | input | NP | New ECN enable mask |
| pause_glb_en | input | 1 | Global gate on pause requests |
| pause_req | output | NP | Pause request per partition |
| drop | output | NP | Drop flag per partition |
| ecn_mark | output | NP | Congestion-mark flag per partition |

## Verification
Some properties are checked on every cycle. Pause stays silent while the global gate is low. An unused partition stays quiet and empty. Occupancy never passes its capacity and moves by at most one credit per cycle unless a size write cleared it. A cleared mask bit keeps its flag low.

Other behaviour needs whole scenarios. The exact threshold arithmetic, the pause hysteresis band between the on and off levels, saturation at both ends, and pulses colliding with a size write are compared cycle by cycle against a reference model. That model is driven through long fill and drain phases.

// File: rtl/rxb_watermark.sv
module rxb_watermark #(
  parameter int NP          = 8,
  parameter int SW          = 8,
  parameter int CW          = 13,
  parameter int FRAME_BYTES = 9728,
  parameter int SKID_CR     = 896,
  parameter logic [NP-1:0] DROP_MASK_RST  = 'h7D,
  parameter logic [NP-1:0] PAUSE_MASK_RST = 'h14,
  parameter logic [NP-1:0] ECN_MASK_RST   = 'h10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NP-1:0]           enq,
  input  logic [NP-1:0]           deq,
  input  logic                    cfg_size_we,
  input  logic [$clog2(NP)-1:0]   cfg_idx,
  input  logic [SW-1:0]           cfg_size,
  input  logic                    cfg_mask_we,
  input  logic [NP-1:0]           cfg_drop_mask,
  input  logic [NP-1:0]           cfg_pause_mask,
  input  logic [NP-1:0]           cfg_ecn_mask,
  input  logic                    pause_glb_en,
  output logic [NP-1:0]           pause_req,
  output logic [NP-1:0]           drop,
  output logic [NP-1:0]           ecn_mark
);
  localparam int IW = $clog2(NP);
  localparam logic [CW-1:0] FRAME_CR = CW'(FRAME_BYTES / 64);
  localparam logic [CW-1:0] SKID     = CW'(SKID_CR);
  localparam logic [CW-1:0] NEVER    = {CW{1'b1}};

  logic [NP-1:0] drop_mask_q, pause_mask_q, ecn_mask_q;
  logic [NP-1:0][CW-1:0] occ_v;
  logic [NP-1:0][SW-1:0] size_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drop_mask_q  <= DROP_MASK_RST;
      pause_mask_q <= PAUSE_MASK_RST;
      ecn_mask_q   <= ECN_MASK_RST;
    end else if (cfg_mask_we) begin
      drop_mask_q  <= cfg_drop_mask;
      pause_mask_q <= cfg_pause_mask;
      ecn_mask_q   <= cfg_ecn_mask;
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_part
    logic [SW-1:0] size_q;
    logic [CW-1:0] occ_q;
    logic          pst_q;
    logic [CW-1:0] sz32, qtr, cap, on_raw, drop_raw, ecn_raw;
    logic [CW-1:0] pon, poff, dth, eth;
    logic          used, hit, pause_now;

    assign used     = |size_q;
    assign hit      = cfg_size_we && (cfg_idx == IW'(i));
    assign sz32     = CW'(size_q) << 5;
    assign qtr      = CW'(size_q) << 3;
    assign cap      = used ? sz32 + CW'(4) : '0;
    assign on_raw   = (sz32 > SKID) ? sz32 - SKID : '0;
    assign drop_raw = (sz32 > FRAME_CR) ? sz32 - FRAME_CR : '0;
    assign ecn_raw  = (qtr > FRAME_CR) ? qtr : FRAME_CR;

    assign pon  = pause_mask_q[i] ? on_raw   : NEVER;
    assign poff = pause_mask_q[i] ? SKID     : NEVER;
    assign dth  = drop_mask_q[i]  ? drop_raw : NEVER;
    assign eth  = ecn_mask_q[i]   ? ecn_raw  : NEVER;

    assign pause_now   = used && ((occ_q >= pon) || (pst_q && (occ_q > poff)));
    assign pause_req[i] = pause_now && pause_glb_en;
    assign drop[i]      = used && (occ_q >= dth);
    assign ecn_mark[i]  = used && (occ_q >= eth);
    assign occ_v[i]     = occ_q;
    assign size_v[i]    = size_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        size_q <= '0;
        occ_q  <= '0;
        pst_q  <= 1'b0;
      end else if (hit) begin
        size_q <= cfg_size;
        occ_q  <= '0;
        pst_q  <= 1'b0;
      end else begin
        pst_q <= pause_now;
        if (enq[i] && !deq[i] && (occ_q < cap))
          occ_q <= occ_q + CW'(1);
        else if (deq[i] && !enq[i] && (occ_q != '0))
          occ_q <= occ_q - CW'(1);
      end
    end
  end
endmodule

// File: rtl/rxb_watermark_chk.sv
module rxb_watermark_chk #(
  parameter int NP = 8,
  parameter int SW = 8,
  parameter int CW = 13
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pause_glb_en,
  input logic                  cfg_size_we,
  input logic [$clog2(NP)-1:0] cfg_idx,
  input logic [NP-1:0][CW-1:0] occ_v,
  input logic [NP-1:0][SW-1:0] size_v,
  input logic [NP-1:0]         drop_mask_q,
  input logic [NP-1:0]         ecn_mask_q,
  input logic [NP-1:0]         pause_req,
  input logic [NP-1:0]         drop,
  input logic [NP-1:0]         ecn_mark
);
  // R8
  pause_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_glb_en |-> (pause_req == '0));

  // R9
  size_write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_size_we |=> (occ_v[$past(cfg_idx)] == '0));

  for (genvar i = 0; i < NP; i++) begin : g_chk
    // R2
    occ_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (size_v[i] != '0) |-> (occ_v[i] <= (CW'(size_v[i]) << 5) + CW'(4)));

    // R2
    occ_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_size_we) |-> ((occ_v[i] == $past(occ_v[i])) ||
                               (occ_v[i] == $past(occ_v[i]) + CW'(1)) ||
                               (occ_v[i] == $past(occ_v[i]) - CW'(1))));

    // R3
    unused_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (size_v[i] == '0) |-> (!drop[i] && !ecn_mark[i] && !pause_req[i] && occ_v[i] == '0));

    // R7
    drop_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !drop_mask_q[i] |-> !drop[i]);

    // R7
    ecn_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ecn_mask_q[i] |-> !ecn_mark[i]);
  end
endmodule

bind rxb_watermark rxb_watermark_chk #(.NP(NP), .SW(SW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pause_glb_en(pause_glb_en),
  .cfg_size_we(cfg_size_we), .cfg_idx(cfg_idx),
  .occ_v(occ_v), .size_v(size_v),
  .drop_mask_q(drop_mask_q), .ecn_mask_q(ecn_mask_q),
  .pause_req(pause_req), .drop(drop), .ecn_mark(ecn_mark)
);

// File: tb/tb_rxb_watermark.sv
module tb_rxb_watermark;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] enq, deq;
  logic       cfg_size_we, cfg_mask_we, pause_glb_en;
  logic [2:0] cfg_idx;
  logic [7:0] cfg_size;
  logic [7:0] cfg_drop_mask, cfg_pause_mask, cfg_ecn_mask;
  logic [7:0] pause_req, drop, ecn_mark;

  always #5 clk = ~clk;

  rxb_watermark dut (
    .clk(clk), .rst_n(rst_n), .enq(enq), .deq(deq),
    .cfg_size_we(cfg_size_we), .cfg_idx(cfg_idx), .cfg_size(cfg_size),
    .cfg_mask_we(cfg_mask_we), .cfg_drop_mask(cfg_drop_mask),
    .cfg_pause_mask(cfg_pause_mask), .cfg_ecn_mask(cfg_ecn_mask),
    .pause_glb_en(pause_glb_en), .pause_req(pause_req), .drop(drop),
    .ecn_mark(ecn_mark)
  );

  int tests = 0, fails = 0;
  int occ_m [8];
  int size_m [8];
  bit pst_m [8];
  logic [7:0] dmask_m, pmask_m, emask_m;
  bit glb_m;

  logic [7:0] nx_enq, nx_deq, nx_dm, nx_pm, nx_em;
  logic       nx_we, nx_mwe, nx_glb;
  logic [2:0] nx_idx;
  logic [7:0] nx_size;

  function automatic int f_cap(int s);
    return (s == 0) ? 0 : s * 32 + 4;
  endfunction
  function automatic int f_pon(int s, bit m);
    return !m ? 8191 : ((s * 32 > 896) ? s * 32 - 896 : 0);
  endfunction
  function automatic int f_poff(bit m);
    return m ? 896 : 8191;
  endfunction
  function automatic int f_dth(int s, bit m);
    return !m ? 8191 : ((s * 32 > 152) ? s * 32 - 152 : 0);
  endfunction
  function automatic int f_eth(int s, bit m);
    return !m ? 8191 : ((s * 8 > 152) ? s * 8 : 152);
  endfunction
  function automatic bit f_pnow(int i);
    return (size_m[i] != 0) &&
           ((occ_m[i] >= f_pon(size_m[i], pmask_m[i])) ||
            (pst_m[i] && occ_m[i] > f_poff(pmask_m[i])));
  endfunction

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick(string tp, string td, string te);
    logic [7:0] ep, ed, ee;
    bit pn [8];
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      pn[i] = f_pnow(i);
      ep[i] = pn[i] && glb_m;
      ed[i] = (size_m[i] != 0) && (occ_m[i] >= f_dth(size_m[i], dmask_m[i]));
      ee[i] = (size_m[i] != 0) && (occ_m[i] >= f_eth(size_m[i], emask_m[i]));
    end
    check(tp, "pause_req", pause_req, ep);
    check(td, "drop", drop, ed);
    check(te, "ecn_mark", ecn_mark, ee);
    enq = nx_enq; deq = nx_deq;
    cfg_size_we = nx_we; cfg_idx = nx_idx; cfg_size = nx_size;
    cfg_mask_we = nx_mwe; cfg_drop_mask = nx_dm; cfg_pause_mask = nx_pm; cfg_ecn_mask = nx_em;
    pause_glb_en = nx_glb;
    for (int i = 0; i < 8; i++) begin
      if (nx_we && nx_idx == 3'(i)) begin
        occ_m[i] = 0; pst_m[i] = 0;
      end else begin
        pst_m[i] = pn[i];
        if (nx_enq[i] && !nx_deq[i] && occ_m[i] < f_cap(size_m[i])) occ_m[i]++;
        else if (nx_deq[i] && !nx_enq[i] && occ_m[i] > 0) occ_m[i]--;
      end
    end
    if (nx_we) size_m[nx_idx] = int'(nx_size);
    if (nx_mwe) begin dmask_m = nx_dm; pmask_m = nx_pm; emask_m = nx_em; end
    glb_m = nx_glb;
  endtask

  task automatic idle_next();
    nx_enq = '0; nx_deq = '0; nx_we = 0; nx_mwe = 0;
  endtask

  task automatic set_size(int idx, int s, string tag);
    idle_next();
    nx_we = 1; nx_idx = 3'(idx); nx_size = 8'(s);
    tick(tag, tag, tag);
  endtask

  task automatic run_phase(int n, int pe, int pd, bit rnd_glb, bit rnd_cfg,
                           string tp, string td, string te);
    for (int c = 0; c < n; c++) begin
      idle_next();
      for (int i = 0; i < 8; i++) begin
        nx_enq[i] = ($urandom % 16) < pe;
        nx_deq[i] = ($urandom % 16) < pd;
      end
      if (rnd_glb && ($urandom % 256) == 0) nx_glb = ~nx_glb;
      if (rnd_cfg && ($urandom % 64) == 0) begin
        nx_we = 1; nx_idx = 3'($urandom % 8); nx_size = 8'($urandom % 64);
      end
      if (rnd_cfg && ($urandom % 128) == 0) begin
        nx_mwe = 1; nx_dm = 8'($urandom); nx_pm = 8'($urandom); nx_em = 8'($urandom);
      end
      tick(tp, td, te);
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired before the run ended");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    rst_n = 0; enq = 0; deq = 0; cfg_size_we = 0; cfg_idx = 0; cfg_size = 0;
    cfg_mask_we = 0; cfg_drop_mask = 0; cfg_pause_mask = 0; cfg_ecn_mask = 0;
    pause_glb_en = 1;
    nx_glb = 1; nx_idx = 0; nx_size = 0; nx_dm = 0; nx_pm = 0; nx_em = 0;
    for (int i = 0; i < 8; i++) begin occ_m[i] = 0; size_m[i] = 0; pst_m[i] = 0; end
    dmask_m = 8'h7D; pmask_m = 8'h14; emask_m = 8'h10; glb_m = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: reset state, then pulses into unused partitions (R3)
    idle_next(); tick("R1", "R1", "R1");
    run_phase(50, 16, 0, 0, 0, "R3", "R3", "R3");

    // R9: sizes written; partition 1 stays unused, partition 4 sits at the skid size
    set_size(0, 40, "R9"); set_size(2, 36, "R9"); set_size(3, 48, "R9");
    set_size(4, 28, "R9"); set_size(5, 60, "R9"); set_size(6, 40, "R9");
    set_size(7, 50, "R9");

    // Fill to saturation, then drain past zero (R2, R4, R5, R6, R11)
    run_phase(3000, 14, 2, 0, 0, "R4", "R5", "R6");
    run_phase(400, 16, 0, 0, 0, "R2", "R2", "R2");
    run_phase(1500, 8, 8, 0, 0, "R2", "R11", "R11");
    run_phase(3000, 2, 14, 0, 0, "R4", "R5", "R6");

    // R10: all masks on, then R8: global pause gate toggling
    idle_next(); nx_mwe = 1; nx_dm = 8'hFF; nx_pm = 8'hFF; nx_em = 8'hFF;
    tick("R10", "R10", "R10");
    run_phase(2500, 14, 2, 1, 0, "R8", "R10", "R10");
    idle_next(); nx_glb = 0; tick("R8", "R8", "R8");
    run_phase(300, 6, 10, 0, 0, "R8", "R8", "R8");
    idle_next(); nx_glb = 1; tick("R8", "R8", "R8");
    run_phase(2500, 2, 14, 1, 0, "R4", "R5", "R6");

    // R7: masks cleared while full
    run_phase(2500, 14, 2, 0, 0, "R4", "R5", "R6");
    idle_next(); nx_mwe = 1; nx_dm = 8'h00; nx_pm = 8'h00; nx_em = 8'h00;
    tick("R7", "R7", "R7");
    run_phase(200, 14, 2, 0, 0, "R7", "R7", "R7");

    // R9: a size write colliding with pulses, then random reconfiguration
    idle_next(); nx_enq = 8'hFF; nx_we = 1; nx_idx = 3'd5; nx_size = 8'd60;
    tick("R9", "R9", "R9");
    run_phase(4000, 11, 5, 1, 1, "R9", "R9", "R9");
    run_phase(20, 0, 0, 0, 0, "R9", "R9", "R9");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule